// File: doc/BRIEF.md
# Dual-Processor Port Mailbox

This block lets two processors share one 8-bit port as a two-way mailbox. Each direction has its own storage. The master processor writes a byte into an outgoing data register. The slave collects that byte by reading the shared pins while its decoded read term is active. In the other direction, the slave puts a byte on the same pins, and a capture stage holds it under the slave's decoded write term. The master reads the captured byte at any time without a handshake.

The slave's strobes are active-low: chip-select, read and write. They are decoded into exactly one of four operations: idle, read, write or clash. Only the read operation turns the pin drivers on. In every other case the pins are released so that the slave can drive them. The pins are split into an input value, an output value and a per-bit output enable, for a pad ring to combine. The slave strobes are taken to be synchronous to the block clock.

The capture stage has two variants, chosen by a parameter. The transparent variant passes the pins straight to the master while the slave writes, and holds the last value sampled. The registered variant presents only the sampled value.

Top module: `mbx_port_mailbox`

## Requirements
- R1: An active-low reset clears the outgoing register and the captured byte to zero. The clear is asynchronous and takes effect while reset is held.
- R2: The slave read term is active when cs_n=0, rd_n=0 and wr_n=1. While it is active, every bit of pin_oe is 1 and pin_out carries the outgoing register.
- R3: The slave write term is active when cs_n=0, wr_n=0 and rd_n=1. A write strobe without chip-select changes nothing that the master can read.
- R4: On a clock edge where mst_wr_en=1, the outgoing register takes mst_wr_data, and pin_out shows it from that edge on.
- R5: In the transparent variant (TRANSPARENT=1), mst_rd_data equals pin_in, with no clock delay, while the slave write term is active.
- R6: On each clock edge with the write term active, the capture stage samples pin_in. Once the term drops, mst_rd_data holds the last sampled value whatever pin_in does.
- R7: If a master write and a slave read fall in the same cycle, the slave sees the old register value. The new value appears from the next cycle.
- R8: pin_oe is all zero whenever cs_n=1, or when rd_n and wr_n are both 0.
- R9: On an edge with mst_wr_en=0, the outgoing register keeps its value whatever mst_wr_data holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mst_wr_en | input | 1 | Master write strobe for the outgoing register |
| mst_wr_data | input | WIDTH | Byte written by the master |
| mst_rd_data | output | WIDTH | Byte captured from the slave, as seen by the master |
| slv_cs_n | input | 1 | Slave chip-select, active low |
| slv_rd_n | input | 1 | Slave read strobe, active low |
| slv_wr_n | input | 1 | Slave write strobe, active low |
| pin_in | input | WIDTH | Value present on the shared pins |
| pin_out | output | WIDTH | Value the block drives onto the pins |
| pin_oe | output | WIDTH | Per-bit pin driver enable, 1 = drive |

## Verification
The bound checker watches these rules on every clock edge:
- the pin-enable decode against the three slave strobes;
- the register load and hold rules for master writes;
- the pass-through path while the slave writes;
- the hold of the captured byte while the slave does not write.

The bench's scenarios cover what the checker cannot:
- the ordering when a master write and a slave read share a cycle;
- that a stray write strobe without chip-select leaves no trace;
- the clear of non-zero state by a reset asserted in the middle of operation.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

   typedef enum logic [1:0] {
      SIDE_IDLE  = 2'd0,
      SIDE_READ  = 2'd1,
      SIDE_WRITE = 2'd2,
      SIDE_CLASH = 2'd3
   } slave_op_e;

   // Classify the active-low slave strobes into one operation.
   function automatic slave_op_e classify(input logic cs_n, input logic rd_n,
                                          input logic wr_n);
      slave_op_e op;
      if (cs_n)                op = SIDE_IDLE;
      else if (!rd_n && wr_n)  op = SIDE_READ;
      else if (!wr_n && rd_n)  op = SIDE_WRITE;
      else if (!rd_n && !wr_n) op = SIDE_CLASH;
      else                     op = SIDE_IDLE;
      return op;
   endfunction

endpackage

// File: rtl/mbx_slave_decode.sv
module mbx_slave_decode
   import mbx_pkg::*;
(
   input  logic      cs_n,
   input  logic      rd_n,
   input  logic      wr_n,
   output slave_op_e op
);
   always_comb op = classify(cs_n, rd_n, wr_n);
endmodule

// File: rtl/mbx_out_reg.sv
module mbx_out_reg #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wr_data,
   output logic [WIDTH-1:0] q
);
   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("mbx_out_reg: WIDTH must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= '0;
      else if (wr_en) q <= wr_data;
   end
endmodule

// File: rtl/mbx_capture.sv
module mbx_capture #(
   parameter int WIDTH       = 8,
   parameter bit TRANSPARENT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_term,
   input  logic [WIDTH-1:0] pin_in,
   output logic [WIDTH-1:0] view
);
   logic [WIDTH-1:0] held;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       held <= '0;
      else if (wr_term) held <= pin_in;
   end

   generate
      if (TRANSPARENT) begin : g_pass
         always_comb view = wr_term ? pin_in : held;
      end else begin : g_held
         always_comb view = held;
      end
   endgenerate
endmodule

// File: rtl/mbx_pin_ctrl.sv
module mbx_pin_ctrl
   import mbx_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  slave_op_e        op,
   input  logic [WIDTH-1:0] out_q,
   output logic [WIDTH-1:0] pin_out,
   output logic [WIDTH-1:0] pin_oe
);
   always_comb begin
      pin_out = out_q;
      pin_oe  = (op == SIDE_READ) ? {WIDTH{1'b1}} : {WIDTH{1'b0}};
   end
endmodule

// File: rtl/mbx_port_mailbox.sv
module mbx_port_mailbox
   import mbx_pkg::*;
#(
   parameter int WIDTH       = 8,
   parameter bit TRANSPARENT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mst_wr_en,
   input  logic [WIDTH-1:0] mst_wr_data,
   output logic [WIDTH-1:0] mst_rd_data,
   input  logic             slv_cs_n,
   input  logic             slv_rd_n,
   input  logic             slv_wr_n,
   input  logic [WIDTH-1:0] pin_in,
   output logic [WIDTH-1:0] pin_out,
   output logic [WIDTH-1:0] pin_oe
);
   generate
      if (WIDTH < 1 || WIDTH > 64) begin : g_bad_width
         $error("mbx_port_mailbox: WIDTH must be 1..64");
      end
   endgenerate

   slave_op_e        op;
   logic             wr_term;
   logic [WIDTH-1:0] out_q;

   mbx_slave_decode u_dec (
      .cs_n(slv_cs_n), .rd_n(slv_rd_n), .wr_n(slv_wr_n), .op(op)
   );

   always_comb wr_term = (op == SIDE_WRITE);

   mbx_out_reg #(.WIDTH(WIDTH)) u_out (
      .clk(clk), .rst_n(rst_n), .wr_en(mst_wr_en),
      .wr_data(mst_wr_data), .q(out_q)
   );

   mbx_capture #(.WIDTH(WIDTH), .TRANSPARENT(TRANSPARENT)) u_cap (
      .clk(clk), .rst_n(rst_n), .wr_term(wr_term),
      .pin_in(pin_in), .view(mst_rd_data)
   );

   mbx_pin_ctrl #(.WIDTH(WIDTH)) u_pins (
      .op(op), .out_q(out_q), .pin_out(pin_out), .pin_oe(pin_oe)
   );
endmodule

// File: rtl/mbx_port_mailbox_chk.sv
module mbx_port_mailbox_chk #(
   parameter int WIDTH       = 8,
   parameter bit TRANSPARENT = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             mst_wr_en,
   input logic [WIDTH-1:0] mst_wr_data,
   input logic [WIDTH-1:0] mst_rd_data,
   input logic             slv_cs_n,
   input logic             slv_rd_n,
   input logic             slv_wr_n,
   input logic [WIDTH-1:0] pin_in,
   input logic [WIDTH-1:0] pin_out,
   input logic [WIDTH-1:0] pin_oe
);
   logic rd_seen, wr_seen;
   always_comb begin
      rd_seen = !slv_cs_n && !slv_rd_n && slv_wr_n;
      wr_seen = !slv_cs_n && !slv_wr_n && slv_rd_n;
   end

   // R2
   rd_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_seen |-> (pin_oe == {WIDTH{1'b1}}));

   // R8
   idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (slv_cs_n || (!slv_rd_n && !slv_wr_n)) |-> (pin_oe == '0));

   // R4
   load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mst_wr_en |=> (pin_out == $past(mst_wr_data)));

   // R9
   keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mst_wr_en |=> $stable(pin_out));

   // R6
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_seen ##1 !wr_seen) |-> $stable(mst_rd_data));

   generate
      if (TRANSPARENT) begin : g_pass_chk
         // R5
         pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wr_seen |-> (mst_rd_data == pin_in));
      end
   endgenerate
endmodule

bind mbx_port_mailbox mbx_port_mailbox_chk #(
   .WIDTH(WIDTH), .TRANSPARENT(TRANSPARENT)
) u_chk (.*);

// File: tb/mbx_port_mailbox_test.sv
module mbx_port_mailbox_test;
   localparam int W = 8;
   localparam int NV = 11;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         mst_wr_en = 1'b0;
   logic [W-1:0] mst_wr_data = '0;
   logic [W-1:0] mst_rd_data;
   logic         slv_cs_n = 1'b1, slv_rd_n = 1'b1, slv_wr_n = 1'b1;
   logic [W-1:0] pin_in = '0;
   logic [W-1:0] pin_out, pin_oe;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #10 clk = ~clk;

   mbx_port_mailbox #(.WIDTH(W), .TRANSPARENT(1'b1)) uut (.*);

   // {cs_n, rd_n, wr_n, wr_en, wr_data, pin_in, exp_oe, exp_pin_out, exp_rd}
   localparam logic [43:0] VEC [NV] = '{
      {4'b1111, 8'hA5, 8'h00, 8'h00, 8'h00, 8'h00},
      {4'b0010, 8'hFF, 8'h00, 8'hFF, 8'hA5, 8'h00},
      {4'b0011, 8'h3C, 8'h00, 8'hFF, 8'hA5, 8'h00},
      {4'b0010, 8'h00, 8'h00, 8'hFF, 8'h3C, 8'h00},
      {4'b0100, 8'h00, 8'h5A, 8'h00, 8'h3C, 8'h5A},
      {4'b0100, 8'h00, 8'h69, 8'h00, 8'h3C, 8'h69},
      {4'b0110, 8'h00, 8'h77, 8'h00, 8'h3C, 8'h69},
      {4'b1100, 8'h00, 8'h11, 8'h00, 8'h3C, 8'h69},
      {4'b0000, 8'h00, 8'h22, 8'h00, 8'h3C, 8'h69},
      {4'b1010, 8'h00, 8'h33, 8'h00, 8'h3C, 8'h69},
      {4'b1110, 8'hEE, 8'h44, 8'h00, 8'h3C, 8'h69}
   };
   localparam string TAG [NV] = '{
      "R4", "R2 R9", "R7", "R7 R2", "R5 R3", "R5 R6",
      "R6", "R3", "R8", "R8", "R9"
   };

   task automatic check(input string req, input string what,
                        input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1", "oe at reset", pin_oe, 8'h00);
      check("R1", "pin_out at reset", pin_out, 8'h00);
      check("R1", "rd_data at reset", mst_rd_data, 8'h00);
      rst_n = 1'b1;
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         {slv_cs_n, slv_rd_n, slv_wr_n, mst_wr_en} = VEC[i][43:40];
         mst_wr_data = VEC[i][39:32];
         pin_in      = VEC[i][31:24];
         #5;
         check(TAG[i], "pin_oe", pin_oe, VEC[i][23:16]);
         check(TAG[i], "pin_out", pin_out, VEC[i][15:8]);
         check(TAG[i], "mst_rd_data", mst_rd_data, VEC[i][7:0]);
      end
      // R1: reset mid-operation, with non-zero state and a slave read active
      @(negedge clk);
      {slv_cs_n, slv_rd_n, slv_wr_n, mst_wr_en} = 4'b0010;
      rst_n = 1'b0;
      #5;
      check("R1", "pin_out after reset", pin_out, 8'h00);
      check("R1", "rd_data after reset", mst_rd_data, 8'h00);
      @(negedge clk);
      rst_n = 1'b1;
      // R6: a write spanning one edge, then pin changes are ignored
      @(negedge clk);
      {slv_cs_n, slv_rd_n, slv_wr_n, mst_wr_en} = 4'b0100;
      pin_in = 8'hC3;
      @(negedge clk);
      {slv_cs_n, slv_rd_n, slv_wr_n} = 3'b111;
      pin_in = 8'h0F;
      #5;
      check("R6", "held after write", mst_rd_data, 8'hC3);
      @(negedge clk);
      #5;
      check("R6", "held later", mst_rd_data, 8'hC3);
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #(20 * 5000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule